// File: doc/BRIEF.md
# Edge-Latched Message-Signalled Interrupt Controller

This block gathers eleven level-type interrupt inputs for a bus bridge and sends each new interrupt to the processor as a memory write instead of driving a wire. Every cycle it samples the inputs into a level register. A 0-to-1 change on an input sets a sticky pending bit. If the source is enabled in the mask, the source also joins a queue of messages that are still to be sent. A per-source class bit chooses one of two programmed target registers. The outbound write goes to that register's value with the low five bits cleared, and its data word is those five low bits.

Software reaches the block through a plain single-cycle register port. Reads are combinational. Reading the pending register clears it, and so does any write to it. Two status words show the live, enabled sources, split by class.

The outbound message leaves through a valid/ready port that carries one beat per message. A beat transfers on a clock edge where `msg_valid` and `msg_ready` are both high. While `msg_ready` is low, the beat stays presented and does not change. The sink may hold `msg_ready` low for as long as it needs. Edges that arrive in the meantime wait in the queue, one bit per source.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset every register reads zero and `msg_valid` is low. Unmapped offsets read zero.
- R2: The level register (offset 0x028) shows the inputs as sampled on the previous clock edge. Writes to it are ignored.
- R3: A pending bit (offset 0x01C, bit i = source i) is set only by a 0-to-1 change of input i, whatever the mask. An input that stays high does not set its bit again once the bit has been cleared.
- R4: Reading offset 0x01C returns the pending bits and then clears them. A write to 0x01C clears them whatever the data. An edge that arrives in the same cycle as the clear still leaves its bit set.
- R5: Status word 0 (offset 0x00C) reads level AND mask AND NOT class. Status word 1 (offset 0x014) reads level AND mask AND class. Writes to both are ignored.
- R6: Target 0 (0x004) and target 1 (0x010) are 32-bit read/write registers. Mask (0x018) and class (0x024) keep bits 10:0 and read zero above bit 10.
- R7: A rising edge of source i with mask bit i set produces one message. It uses target 1 when class bit i is set, and target 0 otherwise. Its address is the chosen target with bits 4:0 forced to zero, and its data is bits 4:0 of that target, zero-extended.
- R8: A rising edge of a source whose mask bit is clear produces no message.
- R9: When several sources wait, their messages go out one at a time, lowest source number first.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| irq_in | input | 11 | Interrupt source levels |
| msg_valid | output | 1 | Outbound write beat valid |
| msg_ready | input | 1 | Sink accepts the beat |
| msg_addr | output | 32 | Outbound write address |
| msg_data | output | 32 | Outbound write data |

## Verification
The case that is hardest to reach from the ports is several sources waiting in the queue together while the sink holds off. Ordering and stall stability can only be seen in that state. The bench keeps `msg_ready` low and raises three sources in one cycle, giving them alternating class bits so the target shows which source sent each message. It then watches the stalled beat for several cycles before draining the queue one handshake at a time.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int unsigned NSRC_DEF   = 11;
  localparam int unsigned DW_DEF     = 32;
  localparam int unsigned OFS_W      = 12;
  localparam int unsigned ALIGN_BITS = 5;

  localparam logic [OFS_W-1:0] OFS_TGT0  = 12'h004;
  localparam logic [OFS_W-1:0] OFS_STAT0 = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_TGT1  = 12'h010;
  localparam logic [OFS_W-1:0] OFS_STAT1 = 12'h014;
  localparam logic [OFS_W-1:0] OFS_MASK  = 12'h018;
  localparam logic [OFS_W-1:0] OFS_PEND  = 12'h01C;
  localparam logic [OFS_W-1:0] OFS_CLASS = 12'h024;
  localparam logic [OFS_W-1:0] OFS_LEVEL = 12'h028;
endpackage

// File: rtl/irq_edge_track.sv
module irq_edge_track #(
  parameter int unsigned NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            pend_clr,
  output logic [NSRC-1:0] level_q,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] rise
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign rise[i] = irq_in[i] & ~level_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        level_q[i] <= 1'b0;
        pend_q[i]  <= 1'b0;
      end else begin
        level_q[i] <= irq_in[i];
        pend_q[i]  <= (pend_q[i] & ~pend_clr) | rise[i];
      end
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_msg_pkg::*;
#(
  parameter int unsigned NSRC = 11,
  parameter int unsigned DW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    tgt0,
  output logic [DW-1:0]    tgt1,
  output logic [NSRC-1:0]  mask,
  output logic [NSRC-1:0]  cls
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt0 <= '0;
      tgt1 <= '0;
      mask <= '0;
      cls  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_TGT0:  tgt0 <= wr_data;
        OFS_TGT1:  tgt1 <= wr_data;
        OFS_MASK:  mask <= wr_data[NSRC-1:0];
        OFS_CLASS: cls  <= wr_data[NSRC-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_msg_queue.sv
module irq_msg_queue #(
  parameter int unsigned NSRC  = 11,
  parameter int unsigned DW    = 32,
  parameter int unsigned ALIGN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] add,
  input  logic [NSRC-1:0] cls,
  input  logic [DW-1:0]   tgt0,
  input  logic [DW-1:0]   tgt1,
  input  logic            ready,
  output logic            valid,
  output logic [DW-1:0]   maddr,
  output logic [DW-1:0]   mdata
);
  logic [NSRC-1:0] wait_q;
  logic [NSRC-1:0] sel_oh;
  logic            any;
  logic            load;
  logic [DW-1:0]   tgt;

  always_comb begin
    sel_oh = '0;
    any    = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (wait_q[i] && !any) begin
        sel_oh[i] = 1'b1;
        any       = 1'b1;
      end
    end
  end

  assign load = any && (!valid || ready);
  assign tgt  = (|(cls & sel_oh)) ? tgt1 : tgt0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= '0;
      valid  <= 1'b0;
      maddr  <= '0;
      mdata  <= '0;
    end else begin
      wait_q <= (wait_q & ~(load ? sel_oh : '0)) | add;
      if (load) begin
        valid <= 1'b1;
        maddr <= {tgt[DW-1:ALIGN], {ALIGN{1'b0}}};
        mdata <= {{(DW-ALIGN){1'b0}}, tgt[ALIGN-1:0]};
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int unsigned NSRC = NSRC_DEF,
  parameter int unsigned DW   = DW_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NSRC-1:0]  irq_in,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [DW-1:0]    msg_addr,
  output logic [DW-1:0]    msg_data
);
  localparam int unsigned PADW = DW - NSRC;

  logic [NSRC-1:0] level_q, pend_q, rise, mask, cls;
  logic [DW-1:0]   tgt0, tgt1;
  logic            pend_clr;

  assign pend_clr = reg_en && (reg_addr == OFS_PEND);

  irq_edge_track #(.NSRC(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pend_clr(pend_clr),
    .level_q(level_q), .pend_q(pend_q), .rise(rise)
  );

  irq_cfg_regs #(.NSRC(NSRC), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_en && reg_we),
    .wr_addr(reg_addr), .wr_data(reg_wdata),
    .tgt0(tgt0), .tgt1(tgt1), .mask(mask), .cls(cls)
  );

  irq_msg_queue #(.NSRC(NSRC), .DW(DW), .ALIGN(ALIGN_BITS)) u_queue (
    .clk(clk), .rst_n(rst_n), .add(rise & mask), .cls(cls),
    .tgt0(tgt0), .tgt1(tgt1), .ready(msg_ready),
    .valid(msg_valid), .maddr(msg_addr), .mdata(msg_data)
  );

  always_comb begin
    case (reg_addr)
      OFS_TGT0:  reg_rdata = tgt0;
      OFS_TGT1:  reg_rdata = tgt1;
      OFS_MASK:  reg_rdata = {{PADW{1'b0}}, mask};
      OFS_CLASS: reg_rdata = {{PADW{1'b0}}, cls};
      OFS_LEVEL: reg_rdata = {{PADW{1'b0}}, level_q};
      OFS_PEND:  reg_rdata = {{PADW{1'b0}}, pend_q};
      OFS_STAT0: reg_rdata = {{PADW{1'b0}}, level_q & mask & ~cls};
      OFS_STAT1: reg_rdata = {{PADW{1'b0}}, level_q & mask & cls};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_msg_chk.sv
module irq_msg_chk
  import irq_msg_pkg::*;
#(
  parameter int unsigned NSRC = 11,
  parameter int unsigned DW   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_en,
  input logic [OFS_W-1:0] reg_addr,
  input logic [NSRC-1:0]  irq_in,
  input logic [NSRC-1:0]  lvl,
  input logic [NSRC-1:0]  pend,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [DW-1:0]    msg_addr,
  input logic [DW-1:0]    msg_data
);
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl == $past(irq_in)); // R2

  AST_EDGE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend & $past(irq_in & ~lvl)) == $past(irq_in & ~lvl)); // R3

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_addr == OFS_PEND) |=> pend == $past(irq_in & ~lvl)); // R4

  AST_MSG_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[ALIGN_BITS-1:0] == '0) && (msg_data[DW-1:ALIGN_BITS] == '0)); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R10
endmodule

bind irq_msg_ctrl irq_msg_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_addr(reg_addr),
  .irq_in(irq_in), .lvl(level_q), .pend(pend_q),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/sim_irq_msg_ctrl.sv
module sim_irq_msg_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [10:0] irq_in = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_msg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic set_in(input logic [10:0] v);
    @(negedge clk);
    irq_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic pop(input string tag, input logic [31:0] ea, input logic [31:0] ed);
    int k;
    k = 0;
    while (!msg_valid && k < 10) begin
      @(negedge clk);
      k++;
    end
    check({tag, " valid"}, {31'd0, msg_valid}, 32'd1);
    check({tag, " addr"}, msg_addr, ea);
    check({tag, " data"}, msg_data, ed);
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  task automatic quiet(input string tag);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (msg_valid) break;
    end
    check(tag, {31'd0, msg_valid}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 msg_valid", {31'd0, msg_valid}, 32'd0);
    rd_chk("R1 tgt0", 12'h004, 0);
    rd_chk("R1 tgt1", 12'h010, 0);
    rd_chk("R1 mask", 12'h018, 0);
    rd_chk("R1 class", 12'h024, 0);
    rd_chk("R1 pend", 12'h01C, 0);
    rd_chk("R1 level", 12'h028, 0);
    rd_chk("R1 unmapped", 12'h100, 0);
  endtask

  task automatic t_regs;
    wr(12'h004, 32'h1234_5667);
    rd_chk("R6 tgt0", 12'h004, 32'h1234_5667);
    wr(12'h010, 32'hCAFE_F00D);
    rd_chk("R6 tgt1", 12'h010, 32'hCAFE_F00D);
    wr(12'h018, 32'hFFFF_FFFF);
    rd_chk("R6 mask width", 12'h018, 32'h7FF);
    wr(12'h024, 32'hFFFF_F0F0);
    rd_chk("R6 class width", 12'h024, 32'h0F0);
    wr(12'h018, 0);
    wr(12'h024, 0);
  endtask

  task automatic t_level_pend;
    set_in(11'h405);
    rd_chk("R2 level", 12'h028, 32'h405);
    wr(12'h028, 0);
    rd_chk("R2 level write ignored", 12'h028, 32'h405);
    rd_chk("R3 pend set", 12'h01C, 32'h405);
    rd_chk("R4 pend cleared by read", 12'h01C, 0);
    repeat (3) @(negedge clk);
    rd_chk("R3 held high no repend", 12'h01C, 0);
    set_in(11'h000);
    set_in(11'h008);
    rd_chk("R3 new edge", 12'h01C, 32'h008);
    set_in(11'h000);
    set_in(11'h010);
    wr(12'h01C, 32'h0000_0000);
    rd_chk("R4 write clears", 12'h01C, 0);
    // edge coinciding with a pending clear keeps its bit
    @(negedge clk);
    irq_in = 11'h012;
    reg_en = 1; reg_we = 1; reg_addr = 12'h01C; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
    rd_chk("R4 same-cycle edge survives", 12'h01C, 32'h002);
    set_in(11'h000);
    rd_chk("R4 drain", 12'h01C, 0);
    quiet("R8 masked-off sources send nothing");
  endtask

  task automatic t_status;
    set_in(11'h00F);
    wr(12'h018, 32'h00F);
    wr(12'h024, 32'h00A);
    rd_chk("R5 status0", 12'h00C, 32'h005);
    rd_chk("R5 status1", 12'h014, 32'h00A);
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h014, 0);
    rd_chk("R5 status0 write ignored", 12'h00C, 32'h005);
    rd_chk("R5 status1 write ignored", 12'h014, 32'h00A);
    quiet("R7 no message without an edge");
    wr(12'h018, 0);
    set_in(11'h000);
    rd_chk("R5 status after drop", 12'h00C, 0);
    wr(12'h01C, 0);
  endtask

  task automatic t_msg;
    wr(12'h004, 32'h8000_0043);
    wr(12'h010, 32'h9000_015F);
    wr(12'h024, 32'h400);
    wr(12'h018, 32'h401);
    set_in(11'h400);
    pop("R7 class1 target", 32'h9000_0140, 32'h0000_001F);
    set_in(11'h401);
    pop("R7 class0 target", 32'h8000_0040, 32'h0000_0003);
    quiet("R7 one message per edge");
    set_in(11'h000);
    set_in(11'h002);
    quiet("R8 unmasked source silent");
    rd_chk("R8 pend still set", 12'h01C, 32'h403);
    set_in(11'h000);
  endtask

  task automatic t_order_stall;
    wr(12'h018, 32'h7FF);
    wr(12'h024, 32'h020);
    set_in(11'h424);
    check("R10 valid while stalled", {31'd0, msg_valid}, 32'd1);
    repeat (3) begin
      @(negedge clk);
      check("R10 stall valid", {31'd0, msg_valid}, 32'd1);
      check("R10 stall addr", msg_addr, 32'h8000_0040);
    end
    pop("R9 first src2", 32'h8000_0040, 32'h3);
    pop("R9 second src5", 32'h9000_0140, 32'h1F);
    pop("R9 third src10", 32'h8000_0040, 32'h3);
    quiet("R9 queue empty");
    set_in(11'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level_pend();
    t_status();
    t_msg();
    t_order_stall();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule